// File: doc/BRIEF.md
# Fuse Programming Sequencer

This block burns a configuration image into a one-time-programmable fuse array. Software first loads the configuration RAM, which the block sees as the parallel input `cfgBits`. It clears the test register and applies the external programming supply. It then sets the start bit in the control register. The sequencer first checks its preconditions. It then walks the fuse addresses from lowest to highest and fires one fixed-length blow pulse for every bit that is set in RAM. After that it reads the whole array back and compares it with RAM. At the end it clears its own start bit and leaves either a success flag or an error flag in the status register.

A failed run can be started again as a retry. Fuses that are already blown are simply pulsed again. A calibration-only pass is a normal run with a RAM image that is zero outside the calibration field. If the programming supply falls away at any point, the sequencer stops at once and reports an error.

Top module: `otp_burn_seq`

## Requirements
- R1: A write of 1 to bit 0 of the control register (address 0x0F) while idle sets the start bit. In the cycle after that write, status (address 0x77) reads busy (bit 2) = 1, success (bit 0) = 0 and error (bit 1) = 0.
- R2: If the test register (address 0x7D) is not 0x00, or `supplyOk` is low, when the sequence begins, the run ends within two cycles with error = 1 and success = 0, and no blow pulse is issued.
- R3: Each address whose RAM bit is 1 receives exactly one blow pulse of `PULSE_CYCLES` consecutive cycles. Pulses are issued in ascending address order. An address whose RAM bit is 0 never sees `fuseBlow` asserted.
- R4: If any fuse read back during the verify phase differs from its RAM bit, the run ends with error = 1 and success = 0. This covers a fuse that failed to blow and a fuse that was already blown where RAM holds 0.
- R5: When every fuse matches RAM, the run ends with success = 1 and error = 0. This includes an image of all zeros, for which no pulse is issued.
- R6: The start bit (control bit 0, also status busy) clears itself when the run ends. Success and error are never both set.
- R7: If `supplyOk` goes low during a run, `fuseBlow` is low and busy is 0 by the next cycle, and error = 1.
- R8: Writes to the control register while busy are ignored. Writing 0 does not stop the run, and writing 1 does not restart it or clear any flag.
- R9: After a failed run, a new start performs a complete retry that can end in success.
- R10: The test register reads back what was written. The status register is read-only. Addresses outside 0x0F, 0x7D and 0x77 read as 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register address for read and write |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for `regAddr` (combinational) |
| cfgBits | input | NUM_BITS | Configuration RAM image to burn |
| supplyOk | input | 1 | Programming supply within range |
| fuseAddr | output | IDX_W | Fuse address for blow and read-back |
| fuseBlow | output | 1 | Fuse blow strobe for `fuseAddr` |
| fuseRdData | input | 1 | Read-back value of the fuse at `fuseAddr` |

## Verification
A wrong sequencer state shows at the fuse port within the same cycle. It can appear as a pulse on an address whose RAM bit is 0, a pulse one cycle too short or too long, or addresses visited out of order. The scoreboard checks each finished pulse against a queue of expected addresses and widths. A corrupted index or comparison shows up only at the end of the run, as the wrong flag in the status register. The failure cases are therefore steered deliberately: a fuse that refuses to blow, a fuse that was blown beforehand, and a supply drop in the middle of a pulse. Each of these makes the flag outcome depend on the verify path.

// File: rtl/otp_burn_pkg.sv
package otp_burn_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_SCAN,
    ST_PULSE,
    ST_VERIFY
  } seqState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic idxClr;
    logic idxInc;
    logic pulseClr;
    logic pulseInc;
    logic setOk;
    logic setErr;
  } seqStrobe_t;

  // Conditions from the datapath to the control FSM
  typedef struct packed {
    logic startBit;
    logic testZero;
    logic lastBit;
    logic pulseDone;
    logic curBit;
    logic fuseMatch;
  } dpStatus_t;

  localparam int STAT_OK_BIT   = 0;
  localparam int STAT_ERR_BIT  = 1;
  localparam int STAT_BUSY_BIT = 2;
  localparam int CTRL_START_BIT = 0;

endpackage

// File: rtl/otp_burn_dpath.sv
module otp_burn_dpath
  import otp_burn_pkg::*;
#(
  parameter int NUM_BITS     = 32,
  parameter int PULSE_CYCLES = 4,
  parameter int REG_AW       = 8,
  parameter int REG_DW       = 8,
  parameter logic [REG_AW-1:0] CTRL_ADDR   = 8'h0F,
  parameter logic [REG_AW-1:0] TEST_ADDR   = 8'h7D,
  parameter logic [REG_AW-1:0] STATUS_ADDR = 8'h77,
  localparam int IDX_W  = (NUM_BITS > 1) ? $clog2(NUM_BITS) : 1,
  localparam int PCNT_W = $clog2(PULSE_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_DW-1:0] regWrData,
  output logic [REG_DW-1:0] regRdData,
  input  logic [NUM_BITS-1:0] cfgBits,
  input  logic              fuseRdData,
  output logic [IDX_W-1:0]  fuseAddr,
  input  seqStrobe_t        stb,
  output dpStatus_t         dpStat
);

  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(NUM_BITS - 1);
  localparam logic [PCNT_W-1:0] LAST_PCNT = PCNT_W'(PULSE_CYCLES - 1);

  logic              startBit;
  logic              okFlag;
  logic              errFlag;
  logic [REG_DW-1:0] testReg;
  logic [IDX_W-1:0]  bitIdx;
  logic [PCNT_W-1:0] pulseCnt;

  logic ctrlWr;
  logic testWr;
  logic startReq;
  logic seqEnd;

  assign ctrlWr   = regWrEn && (regAddr == CTRL_ADDR);
  assign testWr   = regWrEn && (regAddr == TEST_ADDR);
  // A start is accepted only while idle; control writes during a run are dropped
  assign startReq = ctrlWr && regWrData[CTRL_START_BIT] && !startBit;
  assign seqEnd   = stb.setOk || stb.setErr;

  // Control, status and test registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startBit <= 1'b0;
      okFlag   <= 1'b0;
      errFlag  <= 1'b0;
      testReg  <= '0;
    end else begin
      if (seqEnd) begin
        startBit <= 1'b0;
      end else if (startReq) begin
        startBit <= 1'b1;
      end
      if (startReq) begin
        okFlag  <= 1'b0;
        errFlag <= 1'b0;
      end else begin
        if (stb.setOk)  okFlag  <= 1'b1;
        if (stb.setErr) errFlag <= 1'b1;
      end
      if (testWr) begin
        testReg <= regWrData;
      end
    end
  end

  // Fuse index and pulse-length counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitIdx   <= '0;
      pulseCnt <= '0;
    end else begin
      if (stb.idxClr) begin
        bitIdx <= '0;
      end else if (stb.idxInc) begin
        bitIdx <= bitIdx + 1'b1;
      end
      if (stb.pulseClr) begin
        pulseCnt <= '0;
      end else if (stb.pulseInc) begin
        pulseCnt <= pulseCnt + 1'b1;
      end
    end
  end

  // Register read mux
  always_comb begin
    regRdData = '0;
    if (regAddr == CTRL_ADDR) begin
      regRdData[CTRL_START_BIT] = startBit;
    end else if (regAddr == TEST_ADDR) begin
      regRdData = testReg;
    end else if (regAddr == STATUS_ADDR) begin
      regRdData[STAT_OK_BIT]   = okFlag;
      regRdData[STAT_ERR_BIT]  = errFlag;
      regRdData[STAT_BUSY_BIT] = startBit;
    end
  end

  assign fuseAddr          = bitIdx;
  assign dpStat.startBit   = startBit;
  assign dpStat.testZero   = (testReg == '0);
  assign dpStat.lastBit    = (bitIdx == LAST_IDX);
  assign dpStat.pulseDone  = (pulseCnt == LAST_PCNT);
  assign dpStat.curBit     = cfgBits[bitIdx];
  assign dpStat.fuseMatch  = (fuseRdData == cfgBits[bitIdx]);

  // The two outcome flags are mutually exclusive
  assert_flags_exclusive_R6 : assert property (@(posedge clk) disable iff (!rstN)
    !(okFlag && errFlag));

  // The start bit only falls when an outcome is recorded
  assert_start_clears_with_flag_R6 : assert property (@(posedge clk) disable iff (!rstN)
    $fell(startBit) |-> (okFlag || errFlag));

  // While running, the start bit holds until the control FSM ends the run
  assert_ignore_ctrl_busy_R8 : assert property (@(posedge clk) disable iff (!rstN)
    (startBit && !stb.setOk && !stb.setErr) |=> startBit);

  // Accepting a start clears both outcome flags
  assert_start_clears_flags_R1 : assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> (startBit && !okFlag && !errFlag));

endmodule

// File: rtl/otp_burn_ctrl.sv
module otp_burn_ctrl
  import otp_burn_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyOk,
  input  dpStatus_t  dpStat,
  output seqStrobe_t stb,
  output logic       fuseBlow
);

  seqState_t state;
  seqState_t stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  always_comb begin
    stateNext = state;
    stb       = '0;
    unique case (state)
      ST_IDLE: begin
        if (dpStat.startBit) stateNext = ST_CHECK;
      end
      ST_CHECK: begin
        if (!supplyOk || !dpStat.testZero) begin
          stb.setErr = 1'b1;
          stateNext  = ST_IDLE;
        end else begin
          stb.idxClr = 1'b1;
          stateNext  = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (!supplyOk) begin
          stb.setErr = 1'b1;
          stateNext  = ST_IDLE;
        end else if (dpStat.curBit) begin
          stb.pulseClr = 1'b1;
          stateNext    = ST_PULSE;
        end else if (dpStat.lastBit) begin
          stb.idxClr = 1'b1;
          stateNext  = ST_VERIFY;
        end else begin
          stb.idxInc = 1'b1;
        end
      end
      ST_PULSE: begin
        if (!supplyOk) begin
          stb.setErr = 1'b1;
          stateNext  = ST_IDLE;
        end else if (dpStat.pulseDone) begin
          if (dpStat.lastBit) begin
            stb.idxClr = 1'b1;
            stateNext  = ST_VERIFY;
          end else begin
            stb.idxInc = 1'b1;
            stateNext  = ST_SCAN;
          end
        end else begin
          stb.pulseInc = 1'b1;
        end
      end
      ST_VERIFY: begin
        if (!supplyOk || !dpStat.fuseMatch) begin
          stb.setErr = 1'b1;
          stateNext  = ST_IDLE;
        end else if (dpStat.lastBit) begin
          stb.setOk = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          stb.idxInc = 1'b1;
        end
      end
      default: begin
        stb.setErr = 1'b1;
        stateNext  = ST_IDLE;
      end
    endcase
  end

  assign fuseBlow = (state == ST_PULSE);

  // Blow pulses only land on addresses whose RAM bit is set
  assert_blow_only_set_R3 : assert property (@(posedge clk) disable iff (!rstN)
    fuseBlow |-> dpStat.curBit);

  // A supply drop removes the blow strobe on the next cycle
  assert_supply_abort_R7 : assert property (@(posedge clk) disable iff (!rstN)
    (!supplyOk && state != ST_IDLE) |=> (!fuseBlow && state == ST_IDLE));

  // Precondition failure ends the run without entering the scan
  assert_precheck_fail_R2 : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHECK && (!supplyOk || !dpStat.testZero)) |=> (state == ST_IDLE));

  // The FSM only leaves idle on a pending start
  assert_idle_needs_start_R1 : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !dpStat.startBit) |=> (state == ST_IDLE));

endmodule

// File: rtl/otp_burn_seq.sv
module otp_burn_seq
  import otp_burn_pkg::*;
#(
  parameter int NUM_BITS     = 32,
  parameter int PULSE_CYCLES = 4,
  parameter logic [7:0] CTRL_ADDR   = 8'h0F,
  parameter logic [7:0] TEST_ADDR   = 8'h7D,
  parameter logic [7:0] STATUS_ADDR = 8'h77,
  localparam int IDX_W = (NUM_BITS > 1) ? $clog2(NUM_BITS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [7:0]          regAddr,
  input  logic [7:0]          regWrData,
  output logic [7:0]          regRdData,
  input  logic [NUM_BITS-1:0] cfgBits,
  input  logic                supplyOk,
  output logic [IDX_W-1:0]    fuseAddr,
  output logic                fuseBlow,
  input  logic                fuseRdData
);

  seqStrobe_t stb;
  dpStatus_t  dpStat;

  otp_burn_dpath #(
    .NUM_BITS     (NUM_BITS),
    .PULSE_CYCLES (PULSE_CYCLES),
    .REG_AW       (8),
    .REG_DW       (8),
    .CTRL_ADDR    (CTRL_ADDR),
    .TEST_ADDR    (TEST_ADDR),
    .STATUS_ADDR  (STATUS_ADDR)
  ) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .cfgBits    (cfgBits),
    .fuseRdData (fuseRdData),
    .fuseAddr   (fuseAddr),
    .stb        (stb),
    .dpStat     (dpStat)
  );

  otp_burn_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .supplyOk (supplyOk),
    .dpStat   (dpStat),
    .stb      (stb),
    .fuseBlow (fuseBlow)
  );

endmodule

// File: tb/tb_otp_burn_seq.sv
module tb_otp_burn_seq;

  localparam int NB    = 32;
  localparam int PULSE = 4;
  localparam int IW    = $clog2(NB);
  localparam logic [7:0] A_CTRL = 8'h0F;
  localparam logic [7:0] A_TEST = 8'h7D;
  localparam logic [7:0] A_STAT = 8'h77;

  typedef struct {
    int    addr;
    int    width;
    string req;
  } pulse_t;

  typedef struct {
    logic [1:0] flags;
    string      req;
  } result_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic [7:0]    regAddr = A_STAT;
  logic [7:0]    regWrData = '0;
  logic [7:0]    regRdData;
  logic [NB-1:0] cfgBits = '0;
  logic          supplyOk = 1'b1;
  logic [IW-1:0] fuseAddr;
  logic          fuseBlow;
  logic          fuseRdData;
  logic [NB-1:0] fuseArr = '0;

  int checks = 0;
  int errors = 0;
  int weakIdx = -1;

  pulse_t  expPulse[$];
  result_t expResult[$];

  always #10 clk = ~clk;

  assign fuseRdData = fuseArr[fuseAddr];

  otp_burn_seq #(.NUM_BITS(NB), .PULSE_CYCLES(PULSE)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .cfgBits(cfgBits),
    .supplyOk(supplyOk), .fuseAddr(fuseAddr), .fuseBlow(fuseBlow),
    .fuseRdData(fuseRdData)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Fuse model and pulse monitor: a pulse burns only with the full width
  int runAddr = -1;
  int runLen  = 0;
  task automatic finish_pulse();
    pulse_t e;
    if (runLen == PULSE && runAddr != weakIdx) fuseArr[runAddr] = 1'b1;
    if (expPulse.size() == 0) begin
      check(1'b0, "R3 unexpected pulse addr", runAddr, -1);
    end else begin
      e = expPulse.pop_front();
      check(runAddr == e.addr, {e.req, " pulse addr"}, runAddr, e.addr);
      check(runLen == e.width, {e.req, " pulse width"}, runLen, e.width);
    end
    runLen = 0;
    runAddr = -1;
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (fuseBlow) begin
        if (runLen > 0 && int'(fuseAddr) != runAddr) finish_pulse();
        runAddr = int'(fuseAddr);
        runLen++;
      end else if (runLen > 0) begin
        finish_pulse();
      end
    end
  end

  // Result monitor: compares the flags when busy falls
  logic prevBusy = 1'b0;
  always @(negedge clk) begin
    result_t r;
    #1;
    if (rstN && regAddr == A_STAT && !regWrEn) begin
      if (prevBusy && !regRdData[2]) begin
        if (expResult.size() == 0) begin
          check(1'b0, "R6 unexpected end of run", int'(regRdData), 0);
        end else begin
          r = expResult.pop_front();
          check(regRdData[1:0] == r.flags, {r.req, " outcome flags"},
                int'(regRdData[1:0]), int'(r.flags));
        end
      end
      prevBusy = regRdData[2];
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1;
    regAddr = a;
    regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    regAddr = A_STAT;
  endtask

  task automatic read_reg(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    regAddr = a;
    #2;
    v = regRdData;
    @(negedge clk);
    regAddr = A_STAT;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    do begin
      @(negedge clk);
      #3;
      n++;
    end while (regRdData[2] && n < 2000);
    #1;
    check(regRdData[2] == 1'b0, {req, " busy clears"}, int'(regRdData[2]), 0);
    check(expPulse.size() == 0, {req, " all pulses seen"}, expPulse.size(), 0);
    check(expResult.size() == 0, {req, " outcome seen"}, expResult.size(), 0);
    check(regRdData[0] != regRdData[1], "R6 exactly one flag", int'(regRdData[1:0]), 1);
  endtask

  // Driver: queues expected pulses and outcome, then starts the run
  task automatic start_run(input logic [NB-1:0] cfg, input logic [1:0] flags,
                           input logic expectPulses, input string req);
    pulse_t p;
    result_t r;
    cfgBits = cfg;
    if (expectPulses) begin
      for (int i = 0; i < NB; i++) begin
        if (cfg[i]) begin
          p.addr = i; p.width = PULSE; p.req = req;
          expPulse.push_back(p);
        end
      end
    end
    r.flags = flags; r.req = req;
    expResult.push_back(r);
    bus_write(A_CTRL, 8'h01);
    #2;
    check(regRdData[2:0] == 3'b100, "R1 start sets busy clears flags",
          int'(regRdData[2:0]), 4);
  endtask

  task automatic run_seq(input logic [NB-1:0] cfg, input logic [1:0] flags,
                         input logic expectPulses, input string req);
    start_run(cfg, flags, expectPulses, req);
    wait_idle(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int cnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #2;
    // Reset state
    check(regRdData == 8'h00, "R6 reset status", int'(regRdData), 0);
    check(fuseBlow == 1'b0, "R3 reset blow low", int'(fuseBlow), 0);
    read_reg(A_CTRL, v);
    check(v == 8'h00, "R6 reset control", int'(v), 0);

    // Register map
    bus_write(A_TEST, 8'h5A);
    read_reg(A_TEST, v);
    check(v == 8'h5A, "R10 test reg readback", int'(v), 8'h5A);
    bus_write(A_STAT, 8'hFF);
    read_reg(A_STAT, v);
    check(v == 8'h00, "R10 status read-only", int'(v), 0);
    read_reg(8'h33, v);
    check(v == 8'h00, "R10 unmapped reads zero", int'(v), 0);

    // Preconditions: test register nonzero, then supply low
    run_seq(32'h0000_00F1, 2'b10, 1'b0, "R2");
    bus_write(A_TEST, 8'h00);
    supplyOk = 1'b0;
    run_seq(32'h0000_00F1, 2'b10, 1'b0, "R2");
    supplyOk = 1'b1;
    check(fuseArr == '0, "R2 nothing burned", int'(fuseArr), 0);

    // Normal burn with both end addresses set
    run_seq(32'h8000_2C05, 2'b01, 1'b1, "R5");
    check(fuseArr == 32'h8000_2C05, "R3 fuse image", int'(fuseArr), 32'h8000_2C05);
    read_reg(A_CTRL, v);
    check(v == 8'h00, "R6 start bit self-clears", int'(v), 0);

    // Weak fuse fails verify, then retry succeeds
    fuseArr = '0;
    weakIdx = 9;
    run_seq(32'h0000_0F00, 2'b10, 1'b1, "R4");
    weakIdx = -1;
    run_seq(32'h0000_0F00, 2'b01, 1'b1, "R9");
    check(fuseArr == 32'h0000_0F00, "R9 retry image", int'(fuseArr), 32'h0000_0F00);

    // Pre-blown fuse where RAM holds zero
    fuseArr = 32'h0000_0004;
    run_seq(32'h0000_0010, 2'b10, 1'b1, "R4");

    // All-zero image: no pulses, success
    fuseArr = '0;
    run_seq('0, 2'b01, 1'b1, "R5");
    check(fuseArr == '0, "R5 zero image untouched", int'(fuseArr), 0);

    // Control writes during a long run are ignored
    fuseArr = '0;
    start_run('1, 2'b01, 1'b1, "R8");
    repeat (10) @(negedge clk);
    bus_write(A_CTRL, 8'h00);
    #2;
    check(regRdData[2] == 1'b1, "R8 write 0 ignored", int'(regRdData[2]), 1);
    bus_write(A_CTRL, 8'h01);
    #2;
    check(regRdData[2:0] == 3'b100, "R8 write 1 ignored", int'(regRdData[2:0]), 4);
    wait_idle("R8");
    check(fuseArr == '1, "R8 full image", int'(fuseArr), -1);

    // Supply drop mid-pulse, then retry
    fuseArr = '0;
    begin
      pulse_t p;
      p.addr = 5; p.width = 2; p.req = "R7";
      expPulse.push_back(p);
    end
    start_run(32'h0000_0060, 2'b10, 1'b0, "R7");
    cnt = 0;
    while (cnt < 2) begin
      @(negedge clk);
      if (fuseBlow) cnt++;
    end
    supplyOk = 1'b0;
    @(negedge clk);
    #2;
    check(fuseBlow == 1'b0, "R7 blow drops", int'(fuseBlow), 0);
    check(regRdData[2:0] == 3'b010, "R7 abort flags", int'(regRdData[2:0]), 2);
    wait_idle("R7");
    check(fuseArr == '0, "R7 short pulse burns nothing", int'(fuseArr), 0);
    supplyOk = 1'b1;
    run_seq(32'h0000_0060, 2'b01, 1'b1, "R9");
    check(fuseArr == 32'h0000_0060, "R9 image after abort", int'(fuseArr), 32'h60);

    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule